// File: doc/BRIEF.md
# Presettable Cascadable Decade Counter

This block is one decimal digit of a synchronous counter. It holds a four-bit binary-coded decimal value that steps through the codes 0 to 9 and then wraps to 0 on rising clock edges. Software-free control comes from a handful of pins. An active-low clear forces the digit to zero at once, without waiting for a clock. A synchronous load copies a four-bit data word into the digit. Two count enables must both be high for the digit to advance.

A carry output flags the terminal value 9, gated by the second enable. Several digits form a multi-digit decimal counter when every digit receives the same global enable on its first enable and the previous digit's carry on its second enable. The carry chain is combinational, so digit N advances on the edge where all lower digits read 9. Codes 10 to 15 can only enter through the load path. From there they return to the 0 to 9 loop on the next counting edge, so the counter is self-starting.

Top module: `bcd_digit_counter`

## Requirements
- R1: While `rst_n` is low, `count` reads 0000, and it reaches that value without a clock edge.
- R2: With `load` low and both `en_count` and `en_carry` high, each rising edge advances `count` by one from 0 to 8, and from 9 it goes to 0.
- R3: With `load` high, the rising edge places `din` into `count` whatever the enables are, and this includes the codes 10 to 15.
- R4: With `load` low and either enable low, `count` keeps its value across rising edges.
- R5: `carry` is high exactly when `count` is 9 (1001) and `en_carry` is high. It does not depend on `en_count` or `load`.
- R6: A code from 10 to 15 held in `count` keeps `carry` low, and the next counting edge (as in R2) sets `count` to 0.
- R7: Two digits chained as low and high, with the low digit's `carry` on the high digit's `en_carry`, count 00 to 99 and wrap to 00. The high digit's `carry` is high only at 99.
- R8: While `rst_n` is low, neither load nor counting changes `count` from 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low clear of the digit |
| load | input | 1 | Synchronous parallel load request; wins over counting |
| din | input | DIGIT_W (4) | Value loaded into the digit |
| en_count | input | 1 | Count enable; does not gate the carry |
| en_carry | input | 1 | Count enable that also gates the carry output |
| count | output | DIGIT_W (4) | Current digit value |
| carry | output | 1 | High at terminal count 9 while `en_carry` is high |

## Verification
The counting function is exercised in four ways, each of which catches a different kind of fault:
- A free run of more than two full decades separates a wrong wrap point from a wrong increment.
- Loading every one of the 16 codes while the enable pair cycles through all four combinations shows that load wins over counting. The same sweep shows that illegal codes are accepted as loaded.
- Each illegal code is then followed by one counting edge, which shows whether recovery goes to zero and whether the carry stays quiet.
- A two-digit chain run past 99 checks that the combinational carry steps the high digit on exactly the right edge, not one edge early or late.

Holding each enable low on its own at the value 9 shows which enable gates the carry and which only gates counting.

// File: rtl/bcd_digit_pkg.sv
package bcd_digit_pkg;

  // What the digit register does on the next rising edge.
  typedef enum logic [1:0] {
    MODE_HOLD  = 2'd0,
    MODE_LOAD  = 2'd1,
    MODE_COUNT = 2'd2
  } digit_mode_e;

endpackage

// File: rtl/bcd_digit_mode_sel.sv
module bcd_digit_mode_sel
  import bcd_digit_pkg::*;
(
  input  logic        load,
  input  logic        en_count,
  input  logic        en_carry,
  output digit_mode_e mode
);

  // Load has priority; counting needs both enables.
  always_comb begin
    if (load) begin
      mode = MODE_LOAD;
    end else if (en_count && en_carry) begin
      mode = MODE_COUNT;
    end else begin
      mode = MODE_HOLD;
    end
  end

endmodule

// File: rtl/bcd_digit_next.sv
module bcd_digit_next
  import bcd_digit_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10
) (
  input  digit_mode_e        mode,
  input  logic [DIGIT_W-1:0] cur,
  input  logic [DIGIT_W-1:0] din,
  output logic [DIGIT_W-1:0] nxt
);

  localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(RADIX - 1);

  logic [DIGIT_W-1:0] inc;

  generate
    if (RADIX == (1 << DIGIT_W)) begin : g_full_range
      // Every code is legal; natural binary wrap.
      assign inc = cur + DIGIT_W'(1);
    end else begin : g_short_range
      // Terminal and out-of-range codes both return to zero.
      assign inc = (cur >= LAST) ? '0 : cur + DIGIT_W'(1);
    end
  endgenerate

  always_comb begin
    case (mode)
      MODE_LOAD:  nxt = din;
      MODE_COUNT: nxt = inc;
      default:    nxt = cur;
    endcase
  end

endmodule

// File: rtl/bcd_digit_carry.sv
module bcd_digit_carry #(
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10
) (
  input  logic [DIGIT_W-1:0] cur,
  input  logic               en_carry,
  output logic               carry
);

  localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(RADIX - 1);

  always_comb begin
    carry = en_carry && (cur == LAST);
  end

endmodule

// File: rtl/bcd_digit_counter.sv
module bcd_digit_counter
  import bcd_digit_pkg::*;
#(
  parameter int DIGIT_W = 4,
  parameter int RADIX   = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DIGIT_W-1:0] din,
  input  logic               en_count,
  input  logic               en_carry,
  output logic [DIGIT_W-1:0] count,
  output logic               carry
);

  localparam logic [DIGIT_W-1:0] LAST = DIGIT_W'(RADIX - 1);

  digit_mode_e        mode;
  logic [DIGIT_W-1:0] digit_q;
  logic [DIGIT_W-1:0] digit_d;
  logic               digit_upd;

  bcd_digit_mode_sel u_mode_sel (
    .load     (load),
    .en_count (en_count),
    .en_carry (en_carry),
    .mode     (mode)
  );

  bcd_digit_next #(
    .DIGIT_W (DIGIT_W),
    .RADIX   (RADIX)
  ) u_next (
    .mode (mode),
    .cur  (digit_q),
    .din  (din),
    .nxt  (digit_d)
  );

  bcd_digit_carry #(
    .DIGIT_W (DIGIT_W),
    .RADIX   (RADIX)
  ) u_carry (
    .cur      (digit_q),
    .en_carry (en_carry),
    .carry    (carry)
  );

  // Clock enable for the digit register.
  always_comb begin
    digit_upd = (mode != MODE_HOLD);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      digit_q <= '0;
    end else if (digit_upd) begin
      digit_q <= digit_d;
    end
  end

  assign count = digit_q;

  // ---------------------------------------------------------------
  // Assertions
  // ---------------------------------------------------------------
  p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && en_count && en_carry && count < LAST)
      |=> (count == $past(count) + DIGIT_W'(1)))
    else $error("p_step_r2");

  p_wrap_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && en_count && en_carry && count == LAST) |=> (count == '0))
    else $error("p_wrap_r2");

  p_load_r3: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(din)))
    else $error("p_load_r3");

  p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && !(en_count && en_carry)) |=> $stable(count))
    else $error("p_hold_r4");

  p_carry_r5: assert property (@(posedge clk) disable iff (!rst_n)
    carry |-> (count == LAST && en_carry))
    else $error("p_carry_r5");

  p_recover_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load && en_count && en_carry && count > LAST) |=> (count == '0))
    else $error("p_recover_r6");

endmodule

// File: tb/bcd_digit_counter_tb.sv
module bcd_digit_counter_tb;

  logic       clk = 1'b0;
  logic       rst_n;
  logic       load, hi_load;
  logic [3:0] din, hi_din;
  logic       en_count, en_carry, hi_en;
  logic [3:0] count, hi_count;
  logic       carry, hi_carry;

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  bcd_digit_counter u_dut (
    .clk (clk), .rst_n (rst_n), .load (load), .din (din),
    .en_count (en_count), .en_carry (en_carry),
    .count (count), .carry (carry)
  );

  // High digit of the cascade: global enable plus the low digit's carry.
  bcd_digit_counter u_dut_hi (
    .clk (clk), .rst_n (rst_n), .load (hi_load), .din (hi_din),
    .en_count (hi_en), .en_carry (carry),
    .count (hi_count), .carry (hi_carry)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // One rising edge, then settle so outputs are sampled mid-cycle.
  task automatic step();
    @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete (all requirements)");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b1; load = 1'b0; din = '0; en_count = 1'b0; en_carry = 1'b1;
    hi_load = 1'b0; hi_din = '0; hi_en = 1'b0;
    #1 rst_n = 1'b0;
    repeat (3) step();
    chk("R1 reset count", count, 0);
    chk("R1 reset high digit", hi_count, 0);
    chk("R5 carry low at 0", carry, 0);
    rst_n = 1'b1;

    // R2 / R5: free run over more than two decades.
    en_count = 1'b1; en_carry = 1'b1;
    for (int n = 1; n <= 25; n++) begin
      step();
      chk("R2 count sequence", count, n % 10);
      chk("R5 carry at terminal", carry, (n % 10 == 9) ? 1 : 0);
    end

    // R3: load 9, then hold with each enable low in turn (R4, R5).
    load = 1'b1; din = 4'd9;
    step();
    load = 1'b0;
    chk("R3 load 9", count, 9);
    en_count = 1'b0; en_carry = 1'b1; #1;
    chk("R5 carry ignores en_count", carry, 1);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R4 hold en_count low", count, 9);
    end
    en_count = 1'b1; en_carry = 1'b0; #1;
    chk("R5 carry gated by en_carry", carry, 0);
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R4 hold en_carry low", count, 9);
    end
    en_carry = 1'b1; #1;
    chk("R5 carry restored", carry, 1);
    step();
    chk("R2 wrap 9 to 0", count, 0);

    // R3 / R6: every code with all enable combinations, then recovery.
    for (int v = 0; v < 16; v++) begin
      load = 1'b1; din = 4'(v);
      en_count = v[0]; en_carry = v[1];
      step();
      load = 1'b0;
      chk("R3 load priority", count, v);
      if (v >= 10) begin
        en_count = 1'b1; en_carry = 1'b1; #1;
        chk("R6 no carry on illegal code", carry, 0);
        step();
        chk("R6 illegal code recovers to 0", count, 0);
      end
    end

    // R1 / R8: asynchronous clear mid-cycle, then held against load.
    load = 1'b1; din = 4'd6; en_count = 1'b1; en_carry = 1'b1;
    step();
    load = 1'b0;
    chk("R3 load 6", count, 6);
    rst_n = 1'b0;
    #1;
    chk("R1 clear without clock", count, 0);
    load = 1'b1; din = 4'd7;
    for (int k = 0; k < 3; k++) begin
      step();
      chk("R8 clear overrides load", count, 0);
    end
    load = 1'b0;
    rst_n = 1'b1;

    // R7: two-digit cascade past 99.
    en_count = 1'b1; en_carry = 1'b1; hi_en = 1'b1;
    for (int n = 1; n <= 105; n++) begin
      step();
      chk("R7 two-digit value", hi_count * 10 + count, n % 100);
      chk("R7 high carry at 99", hi_carry, (n % 100 == 99) ? 1 : 0);
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule